// File: doc/BRIEF.md
# Differential Mismatch Calibration Search Controller

This controller tunes the calibration of one differential pair of sensing channels whose self-capacitances differ. Two codes act on the pair. A 4-bit binary-weighted code raises the drive of one channel. A 3-bit code adds series resistance to the other channel. A one-bit polarity select decides which channel takes which role. The controller only searches. Each candidate setting goes out on a request/acknowledge handshake, and an external front end returns a magnitude word for the differential output.

After a start pulse, the controller first measures the pair with every code at zero. It then settles the polarity by checking whether any drive code, under the default polarity, lowers that magnitude. After that it runs rounds of coordinate descent. Each round sweeps the drive code with the resistance code held, then sweeps the resistance code with the new drive code held. It stops at the first round that brings no strict improvement and returns the settings of the last improving round. A limit on the number of rounds ends a search that keeps improving and raises a flag.

Top module: `mismatch_cal_fsm`

## Requirements
- R1: After reset, `done`, `overflow` and `meas_req` are low and the three result outputs are zero.
- R2: The first request after `start` carries polarity 0 and zero drive and resistance codes. Its answer is the baseline magnitude.
- R3: The polarity result is 0 if any drive code from 1 to 15, measured with polarity 0 and resistance 0, gives a magnitude strictly below the baseline. Otherwise it is 1.
- R4: Every round requests drive codes 0 to 15 in rising order, then resistance codes 0 to 7 in rising order. A run therefore makes 16 + 24 x rounds measurements.
- R5: A sweep keeps the lowest code that reaches the minimum magnitude, so a later equal result never replaces an earlier one.
- R6: A round whose final magnitude is not strictly below the stored value of the previous round ends the search. The result then holds the codes of the previous round, or zero codes if no round improved.
- R7: When MAX_ITER rounds all improve, the search ends with `overflow` high and the codes of the last round. Otherwise `overflow` is low at `done`.
- R8: While `done` is high and `start` is low, `meas_req` stays low and the results hold. A `start` pulse begins a fresh search.
- R9: While `meas_req` is high and `meas_ack` is low, the candidate outputs hold steady and the request stays up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when idle or done |
| meas_req | output | 1 | A candidate setting is waiting to be measured |
| cand_sel | output | 1 | Candidate polarity select |
| cand_str | output | SW | Candidate drive-strength code |
| cand_res | output | RW | Candidate resistance code |
| meas_ack | input | 1 | Measurement result valid for the current candidate |
| meas_mag | input | MW | Measured output magnitude |
| done | output | 1 | Search finished, results valid |
| overflow | output | 1 | Search ended on the round limit |
| cal_sel | output | 1 | Chosen polarity |
| cal_str | output | SW | Chosen drive code |
| cal_res | output | RW | Chosen resistance code |

## Verification
The behavioural front end has several modes. In the coupled mode, drive and resistance trade against each other, so descent takes more than one round, and the bench uses it with both polarities. An all-flat case makes the first round fail at once, which separates the restore to zero codes from keeping sweep results. In the plateau mode, many codes tie at the minimum, which exposes a sweep that keeps a later equal code. A second instance limited to one round shows whether the overflow path keeps the improved codes where the normal exit restores the old ones.

// File: rtl/mismatch_cal_fsm.sv
module mismatch_cal_fsm #(
  parameter int SW = 4,
  parameter int RW = 3,
  parameter int MW = 16,
  parameter int MAX_ITER = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          meas_req,
  output logic          cand_sel,
  output logic [SW-1:0] cand_str,
  output logic [RW-1:0] cand_res,
  input  logic          meas_ack,
  input  logic [MW-1:0] meas_mag,
  output logic          done,
  output logic          overflow,
  output logic          cal_sel,
  output logic [SW-1:0] cal_str,
  output logic [RW-1:0] cal_res
);
  localparam logic [SW-1:0] S_LAST = SW'((1 << SW) - 1);
  localparam logic [SW-1:0] R_LAST = SW'((1 << RW) - 1);
  localparam int IW = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;

  typedef enum logic [2:0] {S_IDLE, S_BASE, S_CHAN, S_DRV, S_RES, S_DONE} st_t;
  st_t state;

  logic          sel, found, ovf;
  logic [SW-1:0] cnt, s_cur, s_prev, best_code;
  logic [RW-1:0] r_cur, r_prev;
  logic [MW-1:0] o_prev, best_mag;
  logic [IW-1:0] it;

  wire          better   = (cnt == '0) || (meas_mag < best_mag);
  wire [MW-1:0] win_mag  = better ? meas_mag : best_mag;
  wire [SW-1:0] win_code = better ? cnt : best_code;
  wire          lower    = meas_mag < o_prev;

  assign meas_req = (state == S_BASE) || (state == S_CHAN) || (state == S_DRV) || (state == S_RES);
  assign cand_sel = (state == S_DRV || state == S_RES) ? sel : 1'b0;
  assign cand_str = (state == S_CHAN || state == S_DRV) ? cnt : (state == S_RES) ? s_cur : '0;
  assign cand_res = (state == S_RES) ? cnt[RW-1:0] : (state == S_DRV) ? r_cur : '0;
  assign done     = (state == S_DONE);
  assign overflow = ovf;
  assign cal_sel  = sel;
  assign cal_str  = s_cur;
  assign cal_res  = r_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; sel <= 1'b0; found <= 1'b0; ovf <= 1'b0;
      cnt <= '0; s_cur <= '0; s_prev <= '0; best_code <= '0;
      r_cur <= '0; r_prev <= '0; o_prev <= '0; best_mag <= '0; it <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE:
          if (start) begin
            state <= S_BASE; sel <= 1'b0; ovf <= 1'b0; it <= '0;
            s_cur <= '0; r_cur <= '0; s_prev <= '0; r_prev <= '0;
          end
        S_BASE:
          if (meas_ack) begin
            o_prev <= meas_mag; found <= 1'b0; cnt <= SW'(1); state <= S_CHAN;
          end
        S_CHAN:
          if (meas_ack) begin
            if (lower) found <= 1'b1;
            if (cnt == S_LAST) begin
              sel <= !(found || lower); cnt <= '0; state <= S_DRV;
            end else cnt <= cnt + 1'b1;
          end
        S_DRV:
          if (meas_ack) begin
            best_mag <= win_mag; best_code <= win_code;
            if (cnt == S_LAST) begin
              s_cur <= win_code; cnt <= '0; state <= S_RES;
            end else cnt <= cnt + 1'b1;
          end
        S_RES:
          if (meas_ack) begin
            best_mag <= win_mag; best_code <= win_code;
            if (cnt == R_LAST) begin
              state <= S_DONE;
              if (o_prev <= win_mag) begin
                s_cur <= s_prev; r_cur <= r_prev;
              end else begin
                r_cur <= win_code[RW-1:0]; r_prev <= win_code[RW-1:0];
                s_prev <= s_cur; o_prev <= win_mag;
                if (it == IW'(MAX_ITER - 1)) ovf <= 1'b1;
                else begin
                  it <= it + 1'b1; cnt <= '0; state <= S_DRV;
                end
              end
            end else cnt <= cnt + 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mismatch_cal_fsm_chk.sv
module mismatch_cal_fsm_chk #(
  parameter int SW = 4,
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          meas_req,
  input logic          cand_sel,
  input logic [SW-1:0] cand_str,
  input logic [RW-1:0] cand_res,
  input logic          meas_ack,
  input logic          done,
  input logic          overflow,
  input logic          cal_sel,
  input logic [SW-1:0] cal_str,
  input logic [RW-1:0] cal_res
);
  AST_CAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req && !meas_ack |=> meas_req && $stable(cand_sel) && $stable(cand_str) && $stable(cand_res)); // R9
  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(meas_req) |-> !cand_sel && cand_str == '0 && cand_res == '0); // R2
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !meas_req); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(cal_sel) && $stable(cal_str) && $stable(cal_res) && $stable(overflow)); // R8
  AST_NO_OVERFLOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> done); // R7
endmodule

bind mismatch_cal_fsm mismatch_cal_fsm_chk #(.SW(SW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .meas_req(meas_req), .cand_sel(cand_sel),
  .cand_str(cand_str), .cand_res(cand_res), .meas_ack(meas_ack), .done(done),
  .overflow(overflow), .cal_sel(cal_sel), .cal_str(cal_str), .cal_res(cal_res));

// File: tb/sim_mismatch_cal_fsm.sv
module sim_mismatch_cal_fsm;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  always #5 clk = ~clk;

  logic req0, sel0, ack0 = 1'b0, dn0, ov0, csel0; logic [3:0] str0, cstr0; logic [2:0] res0, cres0;
  logic req1, sel1, ack1 = 1'b0, dn1, ov1, csel1; logic [3:0] str1, cstr1; logic [2:0] res1, cres1;
  logic [15:0] mag0 = '0, mag1 = '0;
  int n0 = 0, n1 = 0, checks = 0, fails = 0;
  int m_mode, m_a, m_b, m_c, m_pol;

  mismatch_cal_fsm u0 (.clk(clk), .rst_n(rst_n), .start(start), .meas_req(req0), .cand_sel(sel0),
    .cand_str(str0), .cand_res(res0), .meas_ack(ack0), .meas_mag(mag0), .done(dn0),
    .overflow(ov0), .cal_sel(csel0), .cal_str(cstr0), .cal_res(cres0));
  mismatch_cal_fsm #(.MAX_ITER(1)) u1 (.clk(clk), .rst_n(rst_n), .start(start), .meas_req(req1),
    .cand_sel(sel1), .cand_str(str1), .cand_res(res1), .meas_ack(ack1), .meas_mag(mag1), .done(dn1),
    .overflow(ov1), .cal_sel(csel1), .cal_str(cstr1), .cal_res(cres1));

  function automatic int ab(int x); return x < 0 ? -x : x; endfunction
  function automatic int pos(int x); return x < 0 ? 0 : x; endfunction
  function automatic int fm(int sel, int s, int r);
    if (m_mode == 1)
      return (sel == m_pol) ? m_c + pos(6 - s) + pos(3 - r) : m_c + 9 + s + r;
    return (sel == m_pol) ? ab(m_a - 3*s - r) + ab(m_b - s - 4*r) + m_c
                          : m_a + m_b + m_c + 3*s + 4*r;
  endfunction

  always @(negedge clk) begin
    ack0 <= req0 && !ack0; mag0 <= 16'(fm(int'(sel0), int'(str0), int'(res0)));
    ack1 <= req1 && !ack1; mag1 <= 16'(fm(int'(sel1), int'(str1), int'(res1)));
    if (req0 && !ack0) n0++;
    if (req1 && !ack1) n1++;
  end

  task automatic ref_run(input int lim, output int sel, output int s, output int r,
                         output int ov, output int meas);
    int base, o, sp, rp, bm, bc;
    bit fnd = 0;
    base = fm(0, 0, 0);
    for (int k = 1; k < 16; k++) if (fm(0, k, 0) < base) fnd = 1;
    sel = fnd ? 0 : 1; s = 0; r = 0; o = base; sp = 0; rp = 0; meas = 16; ov = 1;
    for (int i = 0; i < lim; i++) begin
      meas += 24;
      bm = fm(sel, 0, r); bc = 0;
      for (int k = 1; k < 16; k++) if (fm(sel, k, r) < bm) begin bm = fm(sel, k, r); bc = k; end
      s = bc;
      bm = fm(sel, s, 0); bc = 0;
      for (int k = 1; k < 8; k++) if (fm(sel, s, k) < bm) begin bm = fm(sel, s, k); bc = k; end
      if (o <= bm) begin s = sp; r = rp; ov = 0; break; end
      r = bc; o = bm; sp = s; rp = r;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_search();
    n0 = 0; n1 = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!(dn0 && dn1)) @(negedge clk);
  endtask

  task automatic verify(input string nm);
    int es, er, ev, en, ss, rr, oo, nn;
    ref_run(8, ss, es, er, ev, en);
    chk({nm, " R3 sel"}, int'(csel0), ss);
    chk({nm, " R5/R6 str"}, int'(cstr0), es);
    chk({nm, " R5/R6 res"}, int'(cres0), er);
    chk({nm, " R7 ovf"}, int'(ov0), ev);
    chk({nm, " R4 count"}, n0, en);
    ref_run(1, ss, es, er, oo, nn);
    chk({nm, " R7 lim str"}, int'(cstr1), es);
    chk({nm, " R7 lim res"}, int'(cres1), er);
    chk({nm, " R7 lim ovf"}, int'(ov1), oo);
  endtask

  // mode, A, B, C, polarity, expected polarity
  localparam int VEC [6][6] = '{
    '{0, 40, 20, 5, 0, 0}, '{0, 40, 20, 5, 1, 1}, '{0, 10, 30, 0, 0, 0},
    '{0, 7, 7, 2, 1, 1},   '{0, 0, 0, 9, 1, 1},   '{0, 45, 60, 1, 0, 0}};

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    m_mode = 0; m_a = 0; m_b = 0; m_c = 0; m_pol = 0;
    repeat (3) @(negedge clk);
    chk("R1 done", int'(dn0), 0); chk("R1 req", int'(req0), 0); chk("R1 ovf", int'(ov0), 0);
    chk("R1 codes", int'({csel0, cstr0, cres0}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle req", int'(req0), 0);

    for (int v = 0; v < 6; v++) begin
      m_mode = VEC[v][0]; m_a = VEC[v][1]; m_b = VEC[v][2]; m_c = VEC[v][3]; m_pol = VEC[v][4];
      run_search();
      chk($sformatf("vec%0d R3 polarity", v), int'(csel0), VEC[v][5]);
      verify($sformatf("vec%0d", v));
    end

    // R2: first candidate is all zero
    m_mode = 0; m_a = 40; m_b = 20; m_c = 5; m_pol = 1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 req", int'(req0), 1);
    chk("R2 cand", int'({sel0, str0, res0}), 0);
    // R9: candidate held until acknowledged
    @(negedge clk);
    begin
      logic [7:0] snap;
      snap = {sel0, str0, res0};
      @(negedge clk);
      chk("R9 hold", int'({sel0, str0, res0}), int'(snap));
    end
    while (!(dn0 && dn1)) @(negedge clk);

    // R5 plateau: first minimum s=6, r=3, second round ties and restores
    m_mode = 1; m_c = 4; m_pol = 0;
    run_search();
    chk("R5 plateau str", int'(cstr0), 6);
    chk("R5 plateau res", int'(cres0), 3);
    chk("R6 plateau count", n0, 64);
    chk("R7 plateau lim ovf", int'(ov1), 1);

    // R6: flat model restores zero codes at once
    m_mode = 0; m_a = 0; m_b = 0; m_c = 9; m_pol = 1;
    run_search();
    chk("R6 flat str", int'(cstr0), 0);
    chk("R6 flat res", int'(cres0), 0);
    chk("R6 flat ovf1", int'(ov1), 0);

    // R8: results hold while done
    repeat (6) @(negedge clk);
    chk("R8 done held", int'(dn0), 1);
    chk("R8 no req", int'(req0), 0);
    chk("R8 codes held", int'({csel0, cstr0, cres0}), int'({1'b1, 4'd0, 3'd0}));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule